// File: doc/BRIEF.md
# Multi-Bit Shift and Rotate Unit with Carry

This block performs the short-count shift and rotate group of a 16-bit processor datapath, on one register word or on a 32-bit register pair. A start pulse latches a two-bit operation code, a single/double select, a four-bit count field, the operand words and the current carry flag. The unit then moves the operand one bit position per clock cycle. The number of positions is always the count field plus one, so the range is 1 to 16.

Rotates pass through the carry flag. A single rotate uses a 17-bit ring made of the word and C. A double rotate uses a 33-bit ring made of the high word, the low word and C. Arithmetic shifts keep the sign on right shifts and fill with zeros on left shifts. In both directions the last bit shifted out is left in C. When the run ends, the unit raises a one-cycle done pulse. The result words and the N, Z, V, C flags stay on the outputs until the next accepted start. Register file access and instruction fetch belong to the surrounding core.

Top module: `shift_rot_unit`

## Requirements
- R1: A start sampled while the unit is idle latches every input. Later changes on the inputs have no effect on that run. Done is high for exactly one cycle: the cycle that follows the (count+1)-th rising edge after the edge that sampled start. Done is low at every other time.
- R2: A start that arrives while a run is in progress is ignored. The running operation finishes with its own latched inputs, count and timing.
- R3: Operation code 0 is rotate right. In single mode, C enters bit 15 and bit 0 leaves into C, once per position.
- R4: Operation code 1 is rotate left. In single mode, C enters bit 0 and bit 15 leaves into C, once per position.
- R5: Operation code 2 is arithmetic right shift. The sign bit is replicated. After the run, C holds the last bit shifted out of bit 0.
- R6: Operation code 3 is arithmetic left shift. Zeros enter at bit 0. After the run, C holds the last bit shifted out of the top bit.
- R7: In double mode the operand is {high word, low word}, and rotates run over the 33-bit ring high:low:C. In single mode the high result word equals the high operand word.
- R8: N equals the most significant bit of the result: bit 15 of the low word in single mode, bit 15 of the high word in double mode. Z is set exactly when the whole result (one word or both words) is zero. After reset the outputs are zero and Z is 1.
- R9: For an arithmetic left shift, V is set when the top bit changed at any step of the run. For every other operation, V equals N XOR C of the final result.
- R10: The result words and flags hold their values from done until the next start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_sel | input | 2 | 0 rotate right, 1 rotate left, 2 arithmetic right, 3 arithmetic left |
| dbl | input | 1 | 1 selects the 32-bit register-pair form |
| count | input | 4 | Count field; number of positions is count+1 |
| src_lo | input | 16 | Low operand word (single-mode operand) |
| src_hi | input | 16 | High operand word |
| c_in | input | 1 | Current carry flag |
| res_lo | output | 16 | Low result word |
| res_hi | output | 16 | High result word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
The interesting overlap is a new start arriving in the same cycle as the done pulse of the previous run. At that moment the sequencer is idle again and must latch fresh operands, while the outputs still show the old result. The bench causes this on every operation, because each new start is driven in the cycle where the previous done is observed. The bench then checks the next run's latency and result against its model, with the operand inputs scrambled after each start. A second overlap is also exercised: a start pulse injected in the middle of a run must change neither the result nor the done timing.

// File: rtl/shf_pkg.sv
`timescale 1ns/1ps
// Shared types for the shift/rotate unit.
// Assumes: the operation code encoding is fixed by the instruction decoder.
package shf_pkg;
    typedef enum logic [1:0] {
        SH_ROR = 2'd0,
        SH_ROL = 2'd1,
        SH_ASR = 2'd2,
        SH_ASL = 2'd3
    } shf_op_e;
endpackage

// File: rtl/shf_step.sv
`timescale 1ns/1ps
// One-position shift/rotate step on a word or word pair plus carry.
// Assumes: purely combinational; the caller registers the outputs.
module shf_step import shf_pkg::*; #(
    parameter int W = 16
) (
    input  shf_op_e        op,
    input  logic           dbl,
    input  logic [W-1:0]   hi,
    input  logic [W-1:0]   lo,
    input  logic           c,
    output logic [W-1:0]   hi_n,
    output logic [W-1:0]   lo_n,
    output logic           c_n,
    output logic           top_flip
);
    // Next value of the ring or shift register after a single position.
    always_comb begin
        hi_n = hi;
        lo_n = lo;
        c_n  = c;
        case (op)
            SH_ROR: begin
                c_n = lo[0];
                if (dbl) begin
                    lo_n = {hi[0], lo[W-1:1]};
                    hi_n = {c, hi[W-1:1]};
                end else begin
                    lo_n = {c, lo[W-1:1]};
                end
            end
            SH_ROL: begin
                if (dbl) begin
                    c_n  = hi[W-1];
                    hi_n = {hi[W-2:0], lo[W-1]};
                end else begin
                    c_n  = lo[W-1];
                end
                lo_n = {lo[W-2:0], c};
            end
            SH_ASR: begin
                c_n = lo[0];
                if (dbl) begin
                    lo_n = {hi[0], lo[W-1:1]};
                    hi_n = {hi[W-1], hi[W-1:1]};
                end else begin
                    lo_n = {lo[W-1], lo[W-1:1]};
                end
            end
            default: begin
                if (dbl) begin
                    c_n  = hi[W-1];
                    hi_n = {hi[W-2:0], lo[W-1]};
                end else begin
                    c_n  = lo[W-1];
                end
                lo_n = {lo[W-2:0], 1'b0};
            end
        endcase
    end

    // Reports whether this step altered the top bit of the active width.
    always_comb begin
        top_flip = dbl ? (hi_n[W-1] ^ hi[W-1]) : (lo_n[W-1] ^ lo[W-1]);
    end
endmodule

// File: rtl/shf_ctrl.sv
`timescale 1ns/1ps
// Sequencer: accepts a start when idle, counts count+1 steps, pulses done.
// Assumes: start while busy is ignored; the count field is latched at load.
module shf_ctrl #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_field,
    output logic             load,
    output logic             busy,
    output logic             done
);
    localparam int RW = CNT_W + 1;

    logic [RW-1:0] cnt_q;

    // Accept a new operation only while no run is in progress.
    always_comb begin
        load = start && !busy;
    end

    // Step counter, busy state and the done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else if (load) begin
            cnt_q <= {1'b0, cnt_field} + RW'(1);
            busy  <= 1'b1;
            done  <= 1'b0;
        end else if (busy) begin
            cnt_q <= cnt_q - RW'(1);
            busy  <= (cnt_q != RW'(1));
            done  <= (cnt_q == RW'(1));
        end else begin
            done  <= 1'b0;
        end
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R1
    load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    // R2
    busy_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q > RW'(1)) |=> (busy && cnt_q == $past(cnt_q) - RW'(1)));
endmodule

// File: rtl/shf_flags.sv
`timescale 1ns/1ps
// Condition flags derived from the held result registers.
// Assumes: v_acc already holds the sticky sign-change record of a left shift.
module shf_flags import shf_pkg::*; #(
    parameter int W = 16
) (
    input  shf_op_e      op,
    input  logic         dbl,
    input  logic [W-1:0] hi,
    input  logic [W-1:0] lo,
    input  logic         c,
    input  logic         v_acc,
    output logic         n,
    output logic         z,
    output logic         v
);
    // N from the active top bit, Z over the active width, V by operation.
    always_comb begin
        n = dbl ? hi[W-1] : lo[W-1];
        z = dbl ? ~|{hi, lo} : ~|lo;
        v = (op == SH_ASL) ? v_acc : (n ^ c);
    end
endmodule

// File: rtl/shift_rot_unit.sv
`timescale 1ns/1ps
// Iterative multi-bit shift/rotate unit with carry, single word or word pair.
// Assumes: one position per cycle; the result is held until the next start.
module shift_rot_unit import shf_pkg::*; #(
    parameter int W     = 16,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [1:0]       op_sel,
    input  logic             dbl,
    input  logic [CNT_W-1:0] count,
    input  logic [W-1:0]     src_lo,
    input  logic [W-1:0]     src_hi,
    input  logic             c_in,
    output logic [W-1:0]     res_lo,
    output logic [W-1:0]     res_hi,
    output logic             flag_n,
    output logic             flag_z,
    output logic             flag_v,
    output logic             flag_c,
    output logic             done
);
    shf_op_e      op_q;
    logic         dbl_q;
    logic [W-1:0] hi_q, lo_q;
    logic         c_q, v_acc;
    logic         load, busy;
    logic [W-1:0] hi_n, lo_n;
    logic         c_n, top_flip;

    shf_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .cnt_field(count),
        .load(load), .busy(busy), .done(done)
    );

    shf_step #(.W(W)) u_step (
        .op(op_q), .dbl(dbl_q), .hi(hi_q), .lo(lo_q), .c(c_q),
        .hi_n(hi_n), .lo_n(lo_n), .c_n(c_n), .top_flip(top_flip)
    );

    shf_flags #(.W(W)) u_flags (
        .op(op_q), .dbl(dbl_q), .hi(hi_q), .lo(lo_q), .c(c_q), .v_acc(v_acc),
        .n(flag_n), .z(flag_z), .v(flag_v)
    );

    // Operand latch at start, one step per busy cycle, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q  <= SH_ROR;
            dbl_q <= 1'b0;
            hi_q  <= '0;
            lo_q  <= '0;
            c_q   <= 1'b0;
            v_acc <= 1'b0;
        end else if (load) begin
            op_q  <= shf_op_e'(op_sel);
            dbl_q <= dbl;
            hi_q  <= src_hi;
            lo_q  <= src_lo;
            c_q   <= c_in;
            v_acc <= 1'b0;
        end else if (busy) begin
            hi_q  <= hi_n;
            lo_q  <= lo_n;
            c_q   <= c_n;
            v_acc <= v_acc | (top_flip && op_q == SH_ASL);
        end
    end

    // Drive the result ports from the held registers.
    always_comb begin
        res_lo = lo_q;
        res_hi = hi_q;
        flag_c = c_q;
    end

    // R7
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !dbl_q) |=> $stable(hi_q));
    // R10
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(lo_q) && $stable(hi_q) && $stable(c_q)));
    // R5
    asr_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q == SH_ASR) |=> $stable(dbl_q ? hi_q[W-1] : lo_q[W-1]));
    // R9
    v_asl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && op_q != SH_ASL) |=> !v_acc);
endmodule

// File: tb/shift_rot_unit_test.sv
`timescale 1ns/1ps
module shift_rot_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic        dbl = 1'b0;
    logic [3:0]  count = 4'd0;
    logic [15:0] src_lo = '0, src_hi = '0;
    logic        c_in = 1'b0;
    logic [15:0] res_lo, res_hi;
    logic        flag_n, flag_z, flag_v, flag_c, done;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    shift_rot_unit uut (
        .clk(clk), .rst_n(rst_n), .start(start), .op_sel(op_sel), .dbl(dbl),
        .count(count), .src_lo(src_lo), .src_hi(src_hi), .c_in(c_in),
        .res_lo(res_lo), .res_hi(res_hi), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .done(done)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Reference model written from the requirement text.
    task automatic model(input logic [1:0] op, input logic d, input int amt,
                         input logic [15:0] h, input logic [15:0] l, input logic ci,
                         output logic [15:0] rh, output logic [15:0] rl,
                         output logic rc, output logic rv);
        logic [32:0] ring;
        logic [16:0] r17;
        logic signed [31:0] sv;
        logic [31:0] sr;
        logic [63:0] v64, t0, t1;
        int top;
        rh = h; rl = l; rc = ci; rv = 1'b0;
        case (op)
            2'd0, 2'd1: begin
                ring = {h, l, ci};
                r17  = {l, ci};
                for (int k = 0; k < amt; k++) begin
                    if (op == 2'd0) begin
                        ring = {ring[0], ring[32:1]};
                        r17  = {r17[0], r17[16:1]};
                    end else begin
                        ring = {ring[31:0], ring[32]};
                        r17  = {r17[15:0], r17[16]};
                    end
                end
                if (d) begin rh = ring[32:17]; rl = ring[16:1]; rc = ring[0]; end
                else   begin rl = r17[16:1]; rc = r17[0]; end
            end
            2'd2: begin
                sv = d ? {h, l} : {{16{l[15]}}, l};
                sr = sv >>> amt;
                rl = sr[15:0];
                if (d) rh = sr[31:16];
                rc = sv[amt-1];
            end
            default: begin
                v64 = d ? {32'd0, h, l} : {48'd0, l};
                top = d ? 31 : 15;
                for (int k = 1; k <= amt; k++) begin
                    t0 = v64 << (k - 1);
                    t1 = v64 << k;
                    if (t0[top] != t1[top]) rv = 1'b1;
                end
                t1 = v64 << amt;
                rl = t1[15:0];
                if (d) begin rh = t1[31:16]; rc = t1[32]; end
                else   rc = t1[16];
            end
        endcase
    endtask

    function automatic string op_tag(input logic [1:0] op, input logic d);
        if (d) return "R7";
        case (op)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return "R5";
            default: return "R6";
        endcase
    endfunction

    // Starts at a negedge; returns at the negedge where done should be high.
    task automatic run_op(input logic [1:0] op, input logic d, input logic [3:0] cf,
                          input logic [15:0] h, input logic [15:0] l, input logic ci,
                          input bit poke);
        int amt;
        logic [15:0] eh, el;
        logic ec, ev, en, ez;
        bit early;
        string tg;
        amt = int'(cf) + 1;
        model(op, d, amt, h, l, ci, eh, el, ec, ev);
        en = d ? eh[15] : el[15];
        ez = d ? ({eh, el} == 32'd0) : (el == 16'd0);
        if (op != 2'd3) ev = en ^ ec;
        tg = poke ? "R2" : op_tag(op, d);
        op_sel = op; dbl = d; count = cf; src_hi = h; src_lo = l; c_in = ci;
        start = 1'b1;
        @(posedge clk); @(negedge clk);
        start = 1'b0;
        src_hi = 16'($urandom); src_lo = 16'($urandom); op_sel = 2'($urandom);
        dbl = 1'($urandom); count = 4'($urandom); c_in = 1'($urandom);
        early = 1'b0;
        for (int k = 1; k <= amt; k++) begin
            @(posedge clk); @(negedge clk);
            if (k < amt && done) early = 1'b1;
            if (poke && k == 1 && amt >= 2) start = 1'b1;
            if (k == 2) start = 1'b0;
        end
        check(!early && done, poke ? "R2" : "R1", "done timing",
              {31'd0, done}, 32'd1);
        check(res_lo == el, tg, "low word", {16'd0, res_lo}, {16'd0, el});
        check(res_hi == eh, tg, "high word", {16'd0, res_hi}, {16'd0, eh});
        check(flag_c == ec, tg, "carry", {31'd0, flag_c}, {31'd0, ec});
        check(flag_n == en && flag_z == ez, "R8", "N,Z",
              {30'd0, flag_n, flag_z}, {30'd0, en, ez});
        check(flag_v == ev, "R9", "V", {31'd0, flag_v}, {31'd0, ev});
    endtask

    // R10: idle cycles must not disturb the held result.
    task automatic idle_hold(input int n);
        logic [36:0] snap;
        bit saw_done;
        snap = {res_hi, res_lo, flag_n, flag_z, flag_v, flag_c, 1'b0};
        saw_done = 1'b0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk); @(negedge clk);
            if (done) saw_done = 1'b1;
        end
        check({res_hi, res_lo, flag_n, flag_z, flag_v, flag_c, 1'b0} == snap && !saw_done,
              "R10", "hold", {res_hi, res_lo}, snap[36:5]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0C17));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8: reset state
        check(done == 1'b0, "R1", "done after reset", {31'd0, done}, 32'd0);
        check(res_lo == 16'd0 && res_hi == 16'd0 && flag_z, "R8", "reset outputs",
              {res_hi, res_lo}, 32'd0);
        // Directed corners: every op, both widths, minimum and maximum count.
        for (int o = 0; o < 4; o++) begin
            for (int d = 0; d < 2; d++) begin
                run_op(2'(o), 1'(d), 4'd0, 16'h8001, 16'h8001, 1'b1, 1'b0);
                run_op(2'(o), 1'(d), 4'd15, 16'h4001, 16'hC003, 1'b1, 1'b0);
            end
        end
        // R6: full-width left shift of a single word leaves zero, carry from bit 0
        run_op(2'd3, 1'b0, 4'd15, 16'h1234, 16'h0001, 1'b0, 1'b0);
        // R5: sign fill across the whole word
        run_op(2'd2, 1'b0, 4'd15, 16'h0000, 16'h8000, 1'b0, 1'b0);
        // R9: left shift of zero never flips the sign
        run_op(2'd3, 1'b1, 4'd7, 16'h0000, 16'h0000, 1'b1, 1'b0);
        // R2: mid-run start is ignored
        run_op(2'd1, 1'b1, 4'd5, 16'hA5A5, 16'h0FF0, 1'b0, 1'b1);
        idle_hold(4);
        for (int i = 0; i < 300; i++) begin
            run_op(2'($urandom), 1'($urandom), 4'($urandom), 16'($urandom),
                   16'($urandom), 1'($urandom), ($urandom % 8) == 0);
            if (($urandom % 6) == 0) idle_hold(1 + int'($urandom % 3));
        end
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule